// File: doc/BRIEF.md
# Segment lookaside buffer array

A small, fully associative table of segment descriptors. Each entry holds an effective segment identifier (ESID) with a valid flag and a 64-bit segment word. A combinational lookup port maps an effective address onto the matching entry. A command port accepts one operation per cycle:

- a checked slot write;
- a slot read of either word;
- a find-by-address that returns the segment word;
- a single-entry invalidate;
- a bulk invalidate steered by a 3-bit hint.

Results, errors and the flush requests for a downstream translation cache are registered. They appear one cycle after the command.

An entry covers either a 256 MB segment (address bits 63:28) or a 1 TB segment (bits 63:40). Which one is set by the size field in its segment word.

Bulk invalidation normally spares entry 0. With the newest-architecture mode input set, the hint can also sweep entry 0, keep entries by class, or leave the table untouched while still requesting a flush.

Top module: `seg_table`

Field layout used throughout:

- ESID word: ESID in bits 63:28, valid in bit 27, reserved bits 26:12.
  - For write, read-by-slot and the other slot operations, the slot number is in bits 11:0 of `opa_i`.
- Segment word:
  - size in bits 63:62 (00 = 256 MB, 01 = 1 TB, 1x undefined);
  - class in bit 7;
  - page-size selector in bits 6:4.
- Command codes on `cmd_i`:
  - 0 write;
  - 1 read ESID word;
  - 2 read segment word;
  - 3 find;
  - 4 invalidate one;
  - 5 invalidate all;
  - 6 and 7 do nothing.

## Requirements
- R1: An entry hits when it is valid and either its size is 00 and its ESID equals address bits 63:28, or its size is 01 and its ESID equals address bits 63:40 followed by twelve zero bits. A 1 TB entry whose ESID has nonzero low bits never hits.
- R2: When several entries hit, the lookup reports the lowest index. With no hit, `lk_hit_o` is 0 and `lk_seg_o` is 0.
- R3: A write (code 0) is refused, with `err_o` set and the table unchanged, in any of these cases:
  - the slot is at or above N_ENT;
  - any of ESID word bits 26:12 is set;
  - the size field is 1x;
  - the size is 01 while `large_seg_en_i` is 0.
- R4: A write is refused when the page-size selector (bits 6:4) matches none of the PS_ENCS encodings. The default set is 0, 1 and 4.
- R5: Read ESID (code 1) returns {ESID, valid, 27 zero bits}, and read segment (code 2) returns the segment word. Both use only bits 11:0 of `opa_i` as the slot; a slot at or above N_ENT sets `err_o` and leaves `res_valid_o` low.
- R6: Find (code 3) returns the segment word of the hitting entry, or all ones on a miss. With `mode32_i` set, address bits 63:32 are cleared before the search.
- R7: Invalidate-all (code 5) clears every valid bit except entry 0 and pulses `flush_local_o`. This applies to hints 0, 1, 2, 5 and 6, and to every hint when `arch3_i` is 0.
- R8: With `arch3_i` set, hint 4 clears every entry including entry 0. Hint 3 also includes entry 0 but keeps entries whose class bit is 0.
- R9: With `arch3_i` set, hint 7 leaves the table unchanged yet pulses `flush_local_o`.
- R10: Invalidate-one (code 4) clears the lowest hitting entry and pulses `flush_global_o` if `global_i` is set, or `flush_local_o` otherwise. On a miss it raises no flush.
- R11: Reset clears all entries. Results, errors and flushes are registered one cycle after the command and last one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| large_seg_en_i | input | 1 | 1 TB segment support enable |
| arch3_i | input | 1 | Newest-architecture hint handling |
| mode32_i | input | 1 | 32-bit addressing for find |
| lk_ea_i | input | 64 | Lookup effective address |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | $clog2(N_ENT) | Index of hitting entry |
| lk_seg_o | output | 64 | Segment word of hitting entry |
| cmd_valid_i | input | 1 | Command strobe |
| cmd_i | input | 3 | Command code |
| opa_i | input | 64 | ESID word with slot, or address |
| opb_i | input | 64 | Segment word for write |
| hint_i | input | 3 | Bulk invalidate hint |
| global_i | input | 1 | Global flag for invalidate-one |
| res_valid_o | output | 1 | Read/find result valid |
| res_o | output | 64 | Read/find result |
| err_o | output | 1 | Refused write or bad read slot |
| flush_local_o | output | 1 | Local flush request pulse |
| flush_global_o | output | 1 | Global flush request pulse |

## Verification
The assertions assume that only one command is presented per cycle and that a command's strobe and operands are stable across the sampling edge. They also assume that the mode inputs change only between commands. The stimulus drives each command at the falling edge for exactly one cycle. It changes `large_seg_en_i`, `arch3_i` and `mode32_i` only after the edge that consumed the previous command. The table is filled with deliberately overlapping ESIDs and with a 1 TB entry, so that the priority and granularity rules are each reached by a specific address.

// File: rtl/seg_pkg.sv
package seg_pkg;
  localparam int EA_W     = 64;
  localparam int SLOT_W   = 12;
  localparam int ESID_LO  = 28;
  localparam int TB_LO    = 40;
  localparam int ESID_W   = EA_W - ESID_LO;
  localparam int VLD_BIT  = 27;
  localparam int RSV_HI   = 26;
  localparam int RSV_LO   = 12;
  localparam int SZ_HI    = 63;
  localparam int SZ_LO    = 62;
  localparam int CLS_BIT  = 7;
  localparam int PS_LO    = 4;
  localparam int PS_W     = 3;

  typedef enum logic [2:0] {
    CMD_WRITE   = 3'd0,
    CMD_RD_ESID = 3'd1,
    CMD_RD_SEG  = 3'd2,
    CMD_FIND    = 3'd3,
    CMD_INV_ONE = 3'd4,
    CMD_INV_ALL = 3'd5
  } seg_cmd_e;

  localparam logic [1:0] SZ_256M = 2'b00;
  localparam logic [1:0] SZ_1T   = 2'b01;
endpackage

// File: rtl/seg_match.sv
module seg_match
  import seg_pkg::*;
#(
  parameter int N_ENT = 32
) (
  input  logic [EA_W-1:0]               ea_i,
  input  logic [N_ENT-1:0][ESID_W-1:0]  esid_i,
  input  logic [N_ENT-1:0]              vld_i,
  input  logic [N_ENT-1:0]              sz1t_i,
  output logic [N_ENT-1:0]              hit_o
);
  localparam int TB_PAD = TB_LO - ESID_LO;

  logic [ESID_W-1:0] key_256m, key_1t;
  assign key_256m = ea_i[EA_W-1:ESID_LO];
  assign key_1t   = {ea_i[EA_W-1:TB_LO], {TB_PAD{1'b0}}};

  for (genvar i = 0; i < N_ENT; i++) begin : g_ent
    assign hit_o[i] = vld_i[i] &&
                      (sz1t_i[i] ? (esid_i[i] == key_1t) : (esid_i[i] == key_256m));
  end
endmodule

// File: rtl/seg_prio.sv
module seg_prio #(
  parameter int N_ENT = 32,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic [N_ENT-1:0] req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  assign any_o = |req_i;

  always_comb begin
    idx_o = '0;
    for (int i = N_ENT - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/seg_wr_chk.sv
module seg_wr_chk
  import seg_pkg::*;
#(
  parameter int                  PS_CNT  = 3,
  parameter logic [PS_CNT*PS_W-1:0] PS_ENCS = 9'b100_001_000
) (
  input  logic [EA_W-1:0] esid_word_i,
  input  logic [EA_W-1:0] seg_word_i,
  input  logic            large_en_i,
  output logic            ok_o
);
  logic [PS_CNT-1:0] ps_hit;
  logic [1:0]        sz;
  logic              rsv_ok, sz_ok;

  for (genvar k = 0; k < PS_CNT; k++) begin : g_ps
    assign ps_hit[k] = seg_word_i[PS_LO +: PS_W] == PS_ENCS[k*PS_W +: PS_W];
  end

  assign sz     = seg_word_i[SZ_HI:SZ_LO];
  assign rsv_ok = esid_word_i[RSV_HI:RSV_LO] == '0;
  assign sz_ok  = (sz == SZ_256M) || ((sz == SZ_1T) && large_en_i);
  assign ok_o   = rsv_ok && sz_ok && (|ps_hit);
endmodule

// File: rtl/seg_table.sv
module seg_table
  import seg_pkg::*;
#(
  parameter int N_ENT  = 32,
  parameter int PS_CNT = 3,
  parameter logic [PS_CNT*PS_W-1:0] PS_ENCS = 9'b100_001_000,
  localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             large_seg_en_i,
  input  logic             arch3_i,
  input  logic             mode32_i,
  input  logic [63:0]      lk_ea_i,
  output logic             lk_hit_o,
  output logic [IDX_W-1:0] lk_idx_o,
  output logic [63:0]      lk_seg_o,
  input  logic             cmd_valid_i,
  input  logic [2:0]       cmd_i,
  input  logic [63:0]      opa_i,
  input  logic [63:0]      opb_i,
  input  logic [2:0]       hint_i,
  input  logic             global_i,
  output logic             res_valid_o,
  output logic [63:0]      res_o,
  output logic             err_o,
  output logic             flush_local_o,
  output logic             flush_global_o
);
  logic [N_ENT-1:0]             vld_q;
  logic [N_ENT-1:0][ESID_W-1:0] esid_q;
  logic [N_ENT-1:0][EA_W-1:0]   seg_q;
  logic [N_ENT-1:0]             sz1t;

  for (genvar i = 0; i < N_ENT; i++) begin : g_sz
    assign sz1t[i] = seg_q[i][SZ_LO];
  end

  // lookup port
  logic [N_ENT-1:0] lk_hits;
  seg_match #(.N_ENT(N_ENT)) u_lk_match (
    .ea_i(lk_ea_i), .esid_i(esid_q), .vld_i(vld_q), .sz1t_i(sz1t), .hit_o(lk_hits)
  );
  seg_prio #(.N_ENT(N_ENT)) u_lk_prio (
    .req_i(lk_hits), .any_o(lk_hit_o), .idx_o(lk_idx_o)
  );
  assign lk_seg_o = lk_hit_o ? seg_q[lk_idx_o] : '0;

  // command port
  seg_cmd_e         cmd;
  logic [EA_W-1:0]  c_ea;
  logic [N_ENT-1:0] c_hits;
  logic             c_any;
  logic [IDX_W-1:0] c_idx;
  logic             slot_ok, wr_ok;
  logic [IDX_W-1:0] slot;

  assign cmd  = seg_cmd_e'(cmd_i);
  assign c_ea = (cmd == CMD_FIND && mode32_i) ? {32'b0, opa_i[31:0]} : opa_i;

  seg_match #(.N_ENT(N_ENT)) u_cmd_match (
    .ea_i(c_ea), .esid_i(esid_q), .vld_i(vld_q), .sz1t_i(sz1t), .hit_o(c_hits)
  );
  seg_prio #(.N_ENT(N_ENT)) u_cmd_prio (
    .req_i(c_hits), .any_o(c_any), .idx_o(c_idx)
  );
  seg_wr_chk #(.PS_CNT(PS_CNT), .PS_ENCS(PS_ENCS)) u_wr_chk (
    .esid_word_i(opa_i), .seg_word_i(opb_i), .large_en_i(large_seg_en_i), .ok_o(wr_ok)
  );

  assign slot_ok = {1'b0, opa_i[SLOT_W-1:0]} < (SLOT_W+1)'(N_ENT);
  assign slot    = opa_i[IDX_W-1:0];

  // bulk invalidate selection per entry
  logic             hint_none, hint_all, hint_cls;
  logic [N_ENT-1:0] bulk_clr;
  assign hint_none = arch3_i && (hint_i == 3'd7);
  assign hint_all  = arch3_i && (hint_i == 3'd3 || hint_i == 3'd4);
  assign hint_cls  = arch3_i && (hint_i == 3'd3);

  for (genvar i = 0; i < N_ENT; i++) begin : g_bulk
    if (i == 0) begin : g_e0
      assign bulk_clr[i] = !hint_none && hint_all && !(hint_cls && !seg_q[i][CLS_BIT]);
    end else begin : g_en
      assign bulk_clr[i] = !hint_none && !(hint_cls && !seg_q[i][CLS_BIT]);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_q          <= '0;
      esid_q         <= '0;
      seg_q          <= '0;
      res_valid_o    <= 1'b0;
      res_o          <= '0;
      err_o          <= 1'b0;
      flush_local_o  <= 1'b0;
      flush_global_o <= 1'b0;
    end else begin
      res_valid_o    <= 1'b0;
      err_o          <= 1'b0;
      flush_local_o  <= 1'b0;
      flush_global_o <= 1'b0;
      if (cmd_valid_i) begin
        unique case (cmd)
          CMD_WRITE: begin
            if (slot_ok && wr_ok) begin
              esid_q[slot] <= opa_i[EA_W-1:ESID_LO];
              vld_q[slot]  <= opa_i[VLD_BIT];
              seg_q[slot]  <= opb_i;
            end else begin
              err_o <= 1'b1;
            end
          end
          CMD_RD_ESID: begin
            if (slot_ok) begin
              res_valid_o <= 1'b1;
              res_o       <= {esid_q[slot], vld_q[slot], {VLD_BIT{1'b0}}};
            end else begin
              err_o <= 1'b1;
            end
          end
          CMD_RD_SEG: begin
            if (slot_ok) begin
              res_valid_o <= 1'b1;
              res_o       <= seg_q[slot];
            end else begin
              err_o <= 1'b1;
            end
          end
          CMD_FIND: begin
            res_valid_o <= 1'b1;
            res_o       <= c_any ? seg_q[c_idx] : '1;
          end
          CMD_INV_ONE: begin
            if (c_any) begin
              vld_q[c_idx]   <= 1'b0;
              flush_global_o <= global_i;
              flush_local_o  <= !global_i;
            end
          end
          CMD_INV_ALL: begin
            vld_q         <= vld_q & ~bulk_clr;
            flush_local_o <= 1'b1;
          end
          default: ;
        endcase
      end
    end
  end

  // assertions
  assert_wr_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd0 && opa_i[11:0] >= 12'(N_ENT)) |=> err_o);

  assert_lk_lowest_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lk_hit_o |-> (lk_hits[lk_idx_o] &&
                  ((lk_hits & ((N_ENT'(1) << lk_idx_o) - N_ENT'(1))) == '0)));

  assert_find_miss_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd3 && c_hits == '0) |=> (res_valid_o && res_o == '1));

  assert_bulk_keep0_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd5 && !arch3_i) |=>
      (vld_q[N_ENT-1:1] == '0 && vld_q[0] == $past(vld_q[0]) && flush_local_o));

  assert_hint7_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd5 && arch3_i && hint_i == 3'd7) |=>
      ($stable(vld_q) && flush_local_o));

  assert_flush_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({flush_local_o, flush_global_o}));

  assert_inv_miss_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_valid_i && cmd_i == 3'd4 && c_hits == '0) |=> !(flush_local_o || flush_global_o));
endmodule

// File: tb/sim_seg_table.sv
`timescale 1ns/1ps
module sim_seg_table;
  localparam int N_ENT = 32;
  localparam int IDX_W = 5;
  localparam logic [2:0] C_WR = 3'd0, C_RE = 3'd1, C_RS = 3'd2, C_FD = 3'd3,
                         C_I1 = 3'd4, C_IA = 3'd5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic large_en = 1'b1, arch3 = 1'b0, mode32 = 1'b0;
  logic [63:0] lk_ea = '0;
  logic lk_hit; logic [IDX_W-1:0] lk_idx; logic [63:0] lk_seg;
  logic cmd_valid = 1'b0; logic [2:0] cmd = '0;
  logic [63:0] opa = '0, opb = '0; logic [2:0] hint = '0; logic glb = 1'b0;
  logic res_valid; logic [63:0] res; logic err, fl, fg;

  always #10 clk = ~clk;

  seg_table #(.N_ENT(N_ENT)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .large_seg_en_i(large_en), .arch3_i(arch3),
    .mode32_i(mode32), .lk_ea_i(lk_ea), .lk_hit_o(lk_hit), .lk_idx_o(lk_idx),
    .lk_seg_o(lk_seg), .cmd_valid_i(cmd_valid), .cmd_i(cmd), .opa_i(opa),
    .opb_i(opb), .hint_i(hint), .global_i(glb), .res_valid_o(res_valid),
    .res_o(res), .err_o(err), .flush_local_o(fl), .flush_global_o(fg)
  );

  int n_tests = 0, n_fail = 0, cyc = 0;
  bit finished = 1'b0;

  typedef struct {
    logic rv; logic [63:0] res; logic err, fl, fg; string req; int due;
  } exp_t;
  exp_t exp_q[$];

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
    end
  endtask

  // monitor: compare registered outputs one cycle after each command
  always @(negedge clk) begin
    while (exp_q.size() > 0 && exp_q[0].due == cyc) begin
      exp_t e;
      e = exp_q.pop_front();
      chk(res_valid === e.rv, e.req, "res_valid", 64'(res_valid), 64'(e.rv));
      if (e.rv) chk(res === e.res, e.req, "res", res, e.res);
      chk(err === e.err, e.req, "err", 64'(err), 64'(e.err));
      chk(fl === e.fl, e.req, "flush_local", 64'(fl), 64'(e.fl));
      chk(fg === e.fg, e.req, "flush_global", 64'(fg), 64'(e.fg));
    end
  end

  function automatic logic [63:0] ew(input logic [35:0] esid, input logic v);
    return {esid, v, 27'b0};
  endfunction
  function automatic logic [63:0] sw(input logic [1:0] sz, input logic cls,
                                     input logic [2:0] ps, input logic [53:0] vs);
    return {sz, vs, cls, ps, 4'b0};
  endfunction

  task automatic push(input logic rv, input logic [63:0] r, input logic e,
                      input logic f1, input logic f2, input string req);
    exp_t x;
    x.rv = rv; x.res = r; x.err = e; x.fl = f1; x.fg = f2; x.req = req; x.due = cyc + 1;
    exp_q.push_back(x);
  endtask

  task automatic do_cmd(input logic [2:0] c, input logic [63:0] a, input logic [63:0] b,
                        input logic [2:0] h, input logic g, input logic erv,
                        input logic [63:0] eres, input logic eerr, input logic efl,
                        input logic efg, input string req);
    @(negedge clk);
    push(erv, eres, eerr, efl, efg, req);
    cmd_valid = 1'b1; cmd = c; opa = a; opb = b; hint = h; glb = g;
    @(posedge clk);
  endtask

  task automatic idle(input string req);
    @(negedge clk);
    push(1'b0, '0, 1'b0, 1'b0, 1'b0, req);
    cmd_valid = 1'b0;
    @(posedge clk);
  endtask

  task automatic wr(input int slot, input logic [35:0] esid, input logic [63:0] s,
                    input logic eerr, input string req);
    do_cmd(C_WR, ew(esid, 1'b1) | 64'(slot), s, 3'd0, 1'b0, 1'b0, '0, eerr, 1'b0, 1'b0, req);
  endtask

  task automatic chk_lk(input logic [63:0] ea, input logic eh, input int eidx,
                        input logic [63:0] eseg, input string req);
    @(negedge clk);
    push(1'b0, '0, 1'b0, 1'b0, 1'b0, req);
    cmd_valid = 1'b0;
    lk_ea = ea;
    #1;
    chk(lk_hit === eh, req, "lk_hit", 64'(lk_hit), 64'(eh));
    if (eh) chk(lk_idx === IDX_W'(eidx), req, "lk_idx", 64'(lk_idx), 64'(eidx));
    chk(lk_seg === eseg, req, "lk_seg", lk_seg, eseg);
  endtask

  localparam logic [35:0] E5 = {24'hABCDEF, 12'h000};
  logic [63:0] s0, s1, s2, s4, s5, s7, s9, s11;
  localparam logic [63:0] ONES = '1;

  initial begin
    s2 = sw(2'b00, 1'b0, 3'd0, 54'd1);
    s5 = sw(2'b01, 1'b1, 3'd1, 54'd2);
    s7 = sw(2'b00, 1'b1, 3'd4, 54'd3);
    s0 = sw(2'b00, 1'b0, 3'd0, 54'd4);
    s9 = sw(2'b00, 1'b1, 3'd1, 54'd5);
    s11 = sw(2'b01, 1'b0, 3'd0, 54'd6);
    s1 = sw(2'b00, 1'b0, 3'd0, 54'd8);
    s4 = sw(2'b00, 1'b1, 3'd0, 54'd9);

    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R11 reset state
    chk_lk({36'h123, 28'h0}, 1'b0, 0, '0, "R11");
    do_cmd(C_RS, 64'd0, '0, 3'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R11");
    do_cmd(C_RE, 64'd0, '0, 3'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R11");

    // fill
    wr(2, 36'h123, s2, 1'b0, "R1");
    wr(5, E5, s5, 1'b0, "R1");
    wr(7, 36'h123, s7, 1'b0, "R2");
    wr(0, 36'h009, s0, 1'b0, "R6");
    wr(9, 36'h555, s9, 1'b0, "R6");
    wr(11, 36'h777, s11, 1'b0, "R1");

    // R1 / R2 lookups
    chk_lk({36'h123, 28'h1234567}, 1'b1, 2, s2, "R2");
    chk_lk({24'hABCDEF, 12'h345, 28'h1}, 1'b1, 5, s5, "R1");
    chk_lk({36'h124, 28'h0}, 1'b0, 0, '0, "R1");
    chk_lk({36'h777, 28'h10}, 1'b0, 0, '0, "R1");

    // R3 / R4 refused writes
    wr(32, 36'h321, s2, 1'b1, "R3");
    do_cmd(C_WR, ew(36'h321, 1'b1) | 64'd3 | (64'd1 << 20), s2, 3'd0, 1'b0,
           1'b0, '0, 1'b1, 1'b0, 1'b0, "R3");
    wr(3, 36'h321, sw(2'b10, 1'b0, 3'd0, 54'd7), 1'b1, "R3");
    idle("R3");
    large_en = 1'b0;
    wr(3, {24'h111, 12'h0}, sw(2'b01, 1'b0, 3'd0, 54'd7), 1'b1, "R3");
    idle("R3");
    large_en = 1'b1;
    wr(3, 36'h321, sw(2'b00, 1'b0, 3'd3, 54'd7), 1'b1, "R4");
    wr(3, 36'h321, sw(2'b00, 1'b0, 3'd2, 54'd7), 1'b1, "R4");
    do_cmd(C_RS, 64'd3, '0, 3'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R3");
    do_cmd(C_RE, 64'd3, '0, 3'd0, 1'b0, 1'b1, '0, 1'b0, 1'b0, 1'b0, "R3");
    chk_lk({36'h321, 28'h0}, 1'b0, 0, '0, "R3");

    // R5 reads
    do_cmd(C_RE, 64'd2, '0, 3'd0, 1'b0, 1'b1, ew(36'h123, 1'b1), 1'b0, 1'b0, 1'b0, "R5");
    do_cmd(C_RS, 64'hFFFF_0000_0000_F007, '0, 3'd0, 1'b0, 1'b1, s7, 1'b0, 1'b0, 1'b0, "R5");
    do_cmd(C_RS, 64'h20, '0, 3'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R5");
    do_cmd(C_RE, 64'hFFF, '0, 3'd0, 1'b0, 1'b0, '0, 1'b1, 1'b0, 1'b0, "R5");

    // R6 find
    do_cmd(C_FD, {36'h555, 28'hABC}, '0, 3'd0, 1'b0, 1'b1, s9, 1'b0, 1'b0, 1'b0, "R6");
    do_cmd(C_FD, {36'h556, 28'h0}, '0, 3'd0, 1'b0, 1'b1, ONES, 1'b0, 1'b0, 1'b0, "R6");
    do_cmd(C_FD, 64'hDEAD_BEEF_9000_0000, '0, 3'd0, 1'b0, 1'b1, ONES, 1'b0, 1'b0, 1'b0, "R6");
    idle("R6");
    mode32 = 1'b1;
    do_cmd(C_FD, 64'hDEAD_BEEF_9000_0000, '0, 3'd0, 1'b0, 1'b1, s0, 1'b0, 1'b0, 1'b0, "R6");
    idle("R6");
    mode32 = 1'b0;

    // R10 single invalidate
    do_cmd(C_I1, {36'h555, 28'h0}, '0, 3'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b1, "R10");
    do_cmd(C_FD, {36'h555, 28'h0}, '0, 3'd0, 1'b0, 1'b1, ONES, 1'b0, 1'b0, 1'b0, "R10");
    do_cmd(C_I1, {36'h555, 28'h0}, '0, 3'd0, 1'b1, 1'b0, '0, 1'b0, 1'b0, 1'b0, "R10");
    do_cmd(C_I1, {36'h123, 28'h0}, '0, 3'd0, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R10");
    chk_lk({36'h123, 28'h5}, 1'b1, 7, s7, "R10");

    // R7 bulk with arch3 off, hint 3 behaves as default
    do_cmd(C_IA, '0, '0, 3'd3, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R7");
    chk_lk({36'h009, 28'h0}, 1'b1, 0, s0, "R7");
    chk_lk({36'h123, 28'h0}, 1'b0, 0, '0, "R7");
    chk_lk({24'hABCDEF, 12'h0, 28'h0}, 1'b0, 0, '0, "R7");

    wr(1, 36'h00A, s1, 1'b0, "R8");
    wr(4, 36'h00B, s4, 1'b0, "R8");
    idle("R9");
    arch3 = 1'b1;
    do_cmd(C_IA, '0, '0, 3'd7, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R9");
    chk_lk({36'h00B, 28'h0}, 1'b1, 4, s4, "R9");
    chk_lk({36'h00A, 28'h0}, 1'b1, 1, s1, "R9");

    do_cmd(C_IA, '0, '0, 3'd3, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R8");
    chk_lk({36'h00B, 28'h0}, 1'b0, 0, '0, "R8");
    chk_lk({36'h00A, 28'h0}, 1'b1, 1, s1, "R8");
    chk_lk({36'h009, 28'h0}, 1'b1, 0, s0, "R8");

    do_cmd(C_IA, '0, '0, 3'd5, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R7");
    chk_lk({36'h00A, 28'h0}, 1'b0, 0, '0, "R7");
    chk_lk({36'h009, 28'h0}, 1'b1, 0, s0, "R7");

    do_cmd(C_IA, '0, '0, 3'd4, 1'b0, 1'b0, '0, 1'b0, 1'b1, 1'b0, "R8");
    idle("R11");
    chk_lk({36'h009, 28'h0}, 1'b0, 0, '0, "R8");
    idle("R11");
    @(negedge clk);
    @(negedge clk);
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule